// File: doc/BRIEF.md
# Sine-Cosine Correlating Frequency-Response Analyzer

This block measures the loop gain of a sampled control loop at one test frequency. It owns a recursive sine/cosine oscillator that advances once per sample tick. A scaled copy of the sine is added to the controller's output signal before that signal goes on to the limiter and modulator. Over a host-chosen window, the block correlates the controller output with both the sine and the cosine. The host turns the two correlation sums into gain and phase. Choosing the test frequency and computing the Bode plot are left to the host.

Everything is sequenced by one host-writable timer word. At zero the analyzer is idle. Writing one loads the oscillator's starting phasor, and the oscillator then runs while the loop settles. Writing two or more opens the correlation window, and the timer counts one per tick. When the timer reaches the programmed period, the block returns the timer to zero, latches both sums and raises a done flag. The flag stays high until the host starts a new run. The oscillator uses a signed format with 14 fractional bits. The controller signal uses a signed format with 8 fractional bits, so the injected sine is scaled down by 2^6. The injection is combinational from the controller output, so the correlation adds no delay to the loop.

Top module: `fra_analyzer`

## Requirements
- R1: After synchronous reset the timer word, done flag, oscillator sine/cosine and both sum outputs are 0, and vin equals vout.
- R2: While the timer word is 0 and no write occurs, ticks have no effect: the oscillator holds its value and vin equals vout.
- R3: A host write of 1 sets the timer word to 1, loads osc_sin/osc_cos from init_sin/init_cos, clears the internal accumulators and clears done. While the timer word stays at 1, no accumulation happens and the timer word does not change.
- R4: On each tick with the timer word non-zero and no write, the oscillator updates to sin' = sat(floor((k_ss*sin + k_sc*cos)/2^14)) and cos' = sat(floor((k_cs*sin + k_cc*cos)/2^14)). Here sat clamps to the signed 16-bit range [-32768, 32767].
- R5: While the timer word is non-zero, vin = sat(vout + floor(inj_gain*osc_sin/64)). inj_gain is a signed 8-bit integer and sat clamps to signed 16-bit. While the timer word is 0, vin = vout.
- R6: On a tick with the timer word in [2, period) and no write, vout*osc_sin and vout*osc_cos, using the values presented in that cycle, are added to the two accumulators, and the timer word increases by 1.
- R7: In a cycle where the timer word is at least 2 and at least period, with no write, the next cycle shows timer word 0, done 1, and sum_sin/sum_cos equal to the accumulated totals. A window started by writing 2 therefore covers period-2 ticks.
- R8: A host write takes priority over a tick in the same cycle: that tick neither steps the oscillator nor accumulates. Any write clears the accumulators. Writing 0 aborts a run without setting done and leaves sum_sin/sum_cos unchanged.
- R9: sum_sin and sum_cos change only on completion. Once set, done stays high until the host writes 1.
- R10: The accumulators hold the full-scale case exactly: 4094 products of (-32768)*(-32768) give a sum of 4094*2^30 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample tick, one cycle per control sample |
| tmr_we | input | 1 | Host write strobe for the timer word |
| tmr_wdata | input | 13 | Value written to the timer word |
| period | input | 13 | Programmed end count of the timer word |
| init_sin | input | 16 | Starting sine, signed 2.14 |
| init_cos | input | 16 | Starting cosine, signed 2.14 |
| k_ss | input | 16 | Oscillator coefficient, sine to sine, signed 2.14 |
| k_sc | input | 16 | Oscillator coefficient, cosine to sine, signed 2.14 |
| k_cs | input | 16 | Oscillator coefficient, sine to cosine, signed 2.14 |
| k_cc | input | 16 | Oscillator coefficient, cosine to cosine, signed 2.14 |
| inj_gain | input | 8 | Signed injection gain |
| vout | input | 16 | Controller output, signed 8.8 |
| vin | output | 16 | Controller output with injection, signed 8.8 |
| osc_sin | output | 16 | Current oscillator sine |
| osc_cos | output | 16 | Current oscillator cosine |
| tmr_q | output | 13 | Current timer word |
| done | output | 1 | Sums valid |
| sum_sin | output | 44 | Latched correlation with the sine |
| sum_cos | output | 44 | Latched correlation with the cosine |

## Verification
The bench targets the edges of the correlation window. A design that starts or stops counting one tick early or late returns sums over the wrong number of samples and misses the period-2 count. It also covers a write that lands on a tick: if the tick wins, the oscillator moves a step past the loaded phasor. Aborting with a write of 0 must leave the old sums and done untouched; a design that latches or clears there gets this wrong. Saturation of the injected signal and a full-scale 4094-sample window are also driven, and these catch a wrapped vin and an accumulator that is too narrow.

// File: rtl/fra_pkg.sv
package fra_pkg;

    localparam int DATA_W     = 16;
    localparam int OSC_FRAC   = 14;
    localparam int CTRL_FRAC  = 8;
    localparam int GAIN_W     = 8;
    localparam int MAX_PERIOD = 4096;
    localparam int LANES      = 2;

    localparam int TMR_W      = $clog2(MAX_PERIOD + 1);
    localparam int PROD_W     = 2 * DATA_W;
    localparam int WIDE_W     = PROD_W + 1;
    localparam int ACC_W      = PROD_W + $clog2(MAX_PERIOD);
    localparam int INJ_SHIFT  = OSC_FRAC - CTRL_FRAC;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [GAIN_W-1:0] gain_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic        [TMR_W-1:0]  tmr_t;

    typedef struct packed {
        sample_t sn;
        sample_t cs;
    } phasor_t;

    typedef struct packed {
        sample_t k_ss;
        sample_t k_sc;
        sample_t k_cs;
        sample_t k_cc;
    } coef_t;

    typedef struct packed {
        acc_t a_sin;
        acc_t a_cos;
    } sums_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_ACCUM,
        PH_FINISH
    } phase_e;

    localparam sample_t S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam sample_t S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic sample_t sat_sample(input wide_t x);
        if (x > wide_t'(S_MAX)) begin
            return S_MAX;
        end else if (x < wide_t'(S_MIN)) begin
            return S_MIN;
        end
        return sample_t'(x);
    endfunction

    function automatic wide_t mul_wide(input sample_t a, input sample_t b);
        return wide_t'(a) * wide_t'(b);
    endfunction

endpackage

// File: rtl/fra_sequencer.sv
module fra_sequencer
    import fra_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic tmr_we,
    input  tmr_t tmr_wdata,
    input  tmr_t period,
    output tmr_t tmr_q,
    output logic done,
    output logic osc_load,
    output logic osc_step,
    output logic acc_clr,
    output logic acc_en,
    output logic finish,
    output logic inject_on
);

    phase_e phase;

    always_comb begin
        if (tmr_q == '0) begin
            phase = PH_IDLE;
        end else if (tmr_q == tmr_t'(1)) begin
            phase = PH_SETTLE;
        end else if (tmr_q >= period) begin
            phase = PH_FINISH;
        end else begin
            phase = PH_ACCUM;
        end
    end

    assign osc_load  = tmr_we && (tmr_wdata == tmr_t'(1));
    assign osc_step  = tick && !tmr_we && (phase != PH_IDLE);
    assign acc_clr   = tmr_we;
    assign acc_en    = tick && !tmr_we && (phase == PH_ACCUM);
    assign finish    = !tmr_we && (phase == PH_FINISH);
    assign inject_on = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (tmr_we) begin
            tmr_q <= tmr_wdata;
        end else if (finish) begin
            tmr_q <= '0;
        end else if (acc_en) begin
            tmr_q <= tmr_q + tmr_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else if (osc_load) begin
            done <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/fra_oscillator.sv
module fra_oscillator
    import fra_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  logic    step,
    input  phasor_t seed,
    input  coef_t   coef,
    output phasor_t ph
);

    wide_t   mix_s;
    wide_t   mix_c;
    phasor_t ph_next;

    always_comb begin
        mix_s = (mul_wide(coef.k_ss, ph.sn) + mul_wide(coef.k_sc, ph.cs)) >>> OSC_FRAC;
        mix_c = (mul_wide(coef.k_cs, ph.sn) + mul_wide(coef.k_cc, ph.cs)) >>> OSC_FRAC;
        ph_next.sn = sat_sample(mix_s);
        ph_next.cs = sat_sample(mix_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (load) begin
            ph <= seed;
        end else if (step) begin
            ph <= ph_next;
        end
    end

endmodule

// File: rtl/fra_injector.sv
module fra_injector
    import fra_pkg::*;
(
    input  logic    enable,
    input  gain_t   gain,
    input  sample_t sine,
    input  sample_t vout,
    output sample_t vin
);

    wide_t vsig;
    wide_t total;

    always_comb begin
        vsig  = (wide_t'(gain) * wide_t'(sine)) >>> INJ_SHIFT;
        total = wide_t'(vout) + vsig;
        vin   = enable ? sat_sample(total) : vout;
    end

endmodule

// File: rtl/fra_correlator.sv
module fra_correlator
    import fra_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    en,
    input  logic    latch,
    input  sample_t vout,
    input  phasor_t ref_ph,
    output sums_t   result
);

    sample_t ref_lane [LANES];
    acc_t    acc_lane [LANES];
    acc_t    res_lane [LANES];

    assign ref_lane[0] = ref_ph.sn;
    assign ref_lane[1] = ref_ph.cs;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wide_t prod;
        assign prod = mul_wide(vout, ref_lane[g]);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                acc_lane[g] <= '0;
            end else if (en) begin
                acc_lane[g] <= acc_lane[g] + acc_t'(prod);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                res_lane[g] <= '0;
            end else if (latch) begin
                res_lane[g] <= acc_lane[g];
            end
        end
    end

    assign result.a_sin = res_lane[0];
    assign result.a_cos = res_lane[1];

endmodule

// File: rtl/fra_analyzer.sv
module fra_analyzer
    import fra_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     tmr_we,
    input  logic [TMR_W-1:0]         tmr_wdata,
    input  logic [TMR_W-1:0]         period,
    input  logic signed [DATA_W-1:0] init_sin,
    input  logic signed [DATA_W-1:0] init_cos,
    input  logic signed [DATA_W-1:0] k_ss,
    input  logic signed [DATA_W-1:0] k_sc,
    input  logic signed [DATA_W-1:0] k_cs,
    input  logic signed [DATA_W-1:0] k_cc,
    input  logic signed [GAIN_W-1:0] inj_gain,
    input  logic signed [DATA_W-1:0] vout,
    output logic signed [DATA_W-1:0] vin,
    output logic signed [DATA_W-1:0] osc_sin,
    output logic signed [DATA_W-1:0] osc_cos,
    output logic [TMR_W-1:0]         tmr_q,
    output logic                     done,
    output logic signed [ACC_W-1:0]  sum_sin,
    output logic signed [ACC_W-1:0]  sum_cos
);

    logic    osc_load;
    logic    osc_step;
    logic    acc_clr;
    logic    acc_en;
    logic    finish;
    logic    inject_on;
    phasor_t seed;
    coef_t   coef;
    phasor_t ph;
    sums_t   sums;

    assign seed.sn   = init_sin;
    assign seed.cs   = init_cos;
    assign coef.k_ss = k_ss;
    assign coef.k_sc = k_sc;
    assign coef.k_cs = k_cs;
    assign coef.k_cc = k_cc;

    fra_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tmr_we    (tmr_we),
        .tmr_wdata (tmr_wdata),
        .period    (period),
        .tmr_q     (tmr_q),
        .done      (done),
        .osc_load  (osc_load),
        .osc_step  (osc_step),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .finish    (finish),
        .inject_on (inject_on)
    );

    fra_oscillator u_osc (
        .clk  (clk),
        .rst  (rst),
        .load (osc_load),
        .step (osc_step),
        .seed (seed),
        .coef (coef),
        .ph   (ph)
    );

    fra_injector u_inj (
        .enable (inject_on),
        .gain   (inj_gain),
        .sine   (ph.sn),
        .vout   (vout),
        .vin    (vin)
    );

    fra_correlator u_cor (
        .clk    (clk),
        .rst    (rst),
        .clr    (acc_clr),
        .en     (acc_en),
        .latch  (finish),
        .vout   (vout),
        .ref_ph (ph),
        .result (sums)
    );

    assign osc_sin = ph.sn;
    assign osc_cos = ph.cs;
    assign sum_sin = sums.a_sin;
    assign sum_cos = sums.a_cos;

endmodule

// File: rtl/fra_checker.sv
module fra_checker
    import fra_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     tick,
    input logic                     tmr_we,
    input logic [TMR_W-1:0]         tmr_wdata,
    input logic [TMR_W-1:0]         period,
    input logic signed [DATA_W-1:0] init_sin,
    input logic signed [DATA_W-1:0] vout,
    input logic signed [DATA_W-1:0] vin,
    input logic signed [DATA_W-1:0] osc_sin,
    input logic signed [DATA_W-1:0] osc_cos,
    input logic [TMR_W-1:0]         tmr_q,
    input logic                     done,
    input logic signed [ACC_W-1:0]  sum_sin,
    input logic signed [ACC_W-1:0]  sum_cos
);

    logic ends_now;
    assign ends_now = !tmr_we && (tmr_q >= 2) && (tmr_q >= period);

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (tmr_q == '0) |-> (vin == vout)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((tmr_q == '0) && !tmr_we) |=> ($stable(osc_sin) && $stable(osc_cos))); // R2

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tmr_we && (tmr_wdata == TMR_W'(1))) |=> ((osc_sin == $past(init_sin)) && !done && (tmr_q == TMR_W'(1)))); // R3

    AST_SETTLE_STAY: assert property (@(posedge clk) disable iff (rst)
        ((tmr_q == TMR_W'(1)) && !tmr_we) |=> (tmr_q == TMR_W'(1))); // R3

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (!tmr_we && tick && (tmr_q >= 2) && (tmr_q < period)) |=> (tmr_q == $past(tmr_q) + TMR_W'(1))); // R6

    AST_FINISH: assert property (@(posedge clk) disable iff (rst)
        ends_now |=> ((tmr_q == '0) && done)); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        tmr_we |=> (tmr_q == $past(tmr_wdata))); // R8

    AST_SUMS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ends_now |=> ($stable(sum_sin) && $stable(sum_cos))); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !(tmr_we && (tmr_wdata == TMR_W'(1)))) |=> done); // R9

endmodule

bind fra_analyzer fra_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .tmr_we    (tmr_we),
    .tmr_wdata (tmr_wdata),
    .period    (period),
    .init_sin  (init_sin),
    .vout      (vout),
    .vin       (vin),
    .osc_sin   (osc_sin),
    .osc_cos   (osc_cos),
    .tmr_q     (tmr_q),
    .done      (done),
    .sum_sin   (sum_sin),
    .sum_cos   (sum_cos)
);

// File: tb/sim_fra_analyzer.sv
module sim_fra_analyzer;
    import fra_pkg::*;

    logic    clk = 1'b0;
    logic    rst = 1'b1;
    logic    tick = 1'b0;
    logic    tmr_we = 1'b0;
    tmr_t    tmr_wdata = '0;
    tmr_t    period = '0;
    sample_t init_sin = '0, init_cos = '0;
    sample_t k_ss = '0, k_sc = '0, k_cs = '0, k_cc = '0;
    gain_t   inj_gain = '0;
    sample_t vout = '0;
    sample_t vin, osc_sin, osc_cos;
    tmr_t    tmr_q;
    logic    done;
    acc_t    sum_sin, sum_cos;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    fra_analyzer u0 (
        .clk(clk), .rst(rst), .tick(tick), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
        .period(period), .init_sin(init_sin), .init_cos(init_cos),
        .k_ss(k_ss), .k_sc(k_sc), .k_cs(k_cs), .k_cc(k_cc), .inj_gain(inj_gain),
        .vout(vout), .vin(vin), .osc_sin(osc_sin), .osc_cos(osc_cos),
        .tmr_q(tmr_q), .done(done), .sum_sin(sum_sin), .sum_cos(sum_cos)
    );

    // behavioural reference state
    int     m_tmr, m_sin, m_cos, m_done;
    longint m_as, m_ac, m_rs, m_rc;

    function automatic int clamp16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    function automatic int rot(int ka, int a, int kb, int b);
        longint p;
        p = longint'(ka) * a + longint'(kb) * b;
        return clamp16(p >>> 14);
    endfunction

    function automatic int exp_vin();
        longint s;
        if (m_tmr == 0) return int'(vout);
        s = longint'(vout) + ((longint'(inj_gain) * m_sin) >>> 6);
        return clamp16(s);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int o_t, o_s, o_c;
        cyc++;
        if (rst) begin
            m_tmr = 0; m_sin = 0; m_cos = 0; m_done = 0;
            m_as = 0; m_ac = 0; m_rs = 0; m_rc = 0;
        end else begin
            o_t = m_tmr; o_s = m_sin; o_c = m_cos;
            if (tmr_we) begin
                m_tmr = int'(tmr_wdata);
                m_as = 0; m_ac = 0;
                if (tmr_wdata == 1) begin
                    m_done = 0; m_sin = int'(init_sin); m_cos = int'(init_cos);
                end
            end else if (o_t >= 2 && o_t >= int'(period)) begin
                m_tmr = 0; m_done = 1; m_rs = m_as; m_rc = m_ac;
            end else if (tick && o_t >= 2) begin
                m_as += longint'(vout) * o_s;
                m_ac += longint'(vout) * o_c;
                m_tmr = o_t + 1;
            end
            if (!tmr_we && tick && o_t != 0) begin
                m_sin = rot(int'(k_ss), o_s, int'(k_sc), o_c);
                m_cos = rot(int'(k_cs), o_s, int'(k_cc), o_c);
            end
        end
    end

    // per-cycle comparison, sampled 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check(int'(tmr_q) == m_tmr, "R6 timer word", longint'(tmr_q), m_tmr);
            check(int'(done) == m_done, "R9 done flag", longint'(done), m_done);
            check(int'(osc_sin) == m_sin && int'(osc_cos) == m_cos, "R4 oscillator sine", longint'(osc_sin), m_sin);
            check(int'(vin) == exp_vin(), "R5 injected vin", longint'(vin), exp_vin());
            check(longint'(sum_sin) == m_rs && longint'(sum_cos) == m_rc, "R7 sum_sin", longint'(sum_sin), m_rs);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic host_write(input int v);
        @(negedge clk);
        tmr_we = 1'b1; tmr_wdata = tmr_t'(v); tick = 1'b0;
        @(negedge clk);
        tmr_we = 1'b0;
    endtask

    task automatic run(input int n, input int every, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (i % every) == 0;
            vout = sample_t'(((i * 37 + seed) % 2001) - 1000);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic run_to_done(input int every, input int seed);
        int i = 0;
        while (!done && i < 20000) begin
            @(negedge clk);
            tick = (i % every) == 0;
            vout = sample_t'(((i * 53 + seed) % 1501) - 750);
            i++;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_rotation();
        k_ss = 16'sd16305; k_sc = 16'sd1606; k_cs = -16'sd1606; k_cc = 16'sd16305;
    endtask

    initial begin
        longint keep_s, keep_c;
        longint full;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        vout = 16'sd123;
        @(negedge clk);
        // R1 reset state
        check(tmr_q == 0 && done == 0, "R1 reset timer/done", longint'(tmr_q), 0);
        check(osc_sin == 0 && osc_cos == 0, "R1 reset oscillator", longint'(osc_sin), 0);
        check(sum_sin == 0 && sum_cos == 0, "R1 reset sums", longint'(sum_sin), 0);
        check(vin == vout, "R1 reset vin pass", longint'(vin), longint'(vout));

        // R2 idle ticks do nothing
        set_rotation(); inj_gain = 8'sd20; init_sin = 16'sd0; init_cos = 16'sd16000;
        run(12, 1, 5);
        check(osc_sin == 0 && osc_cos == 0, "R2 idle oscillator held", longint'(osc_cos), 0);

        // R3 start and settle, R4 rotation, R6/R7 window of period-2 ticks
        period = tmr_t'(40);
        host_write(1);
        check(osc_cos == init_cos && tmr_q == 1, "R3 start loads seed", longint'(osc_cos), longint'(init_cos));
        run(40, 2, 11);
        check(tmr_q == 1 && done == 0, "R3 settle timer stays 1", longint'(tmr_q), 1);
        host_write(2);
        run_to_done(2, 7);
        check(done == 1 && tmr_q == 0, "R7 completion", longint'(done), 1);
        check(sum_sin == m_rs && sum_cos == m_rc && m_rs != 0, "R6 sums after window", longint'(sum_cos), m_rc);

        // R8 write in the same cycle as a tick
        @(negedge clk);
        tmr_we = 1'b1; tmr_wdata = tmr_t'(1); tick = 1'b1;
        @(negedge clk);
        tmr_we = 1'b0; tick = 1'b0;
        check(osc_sin == init_sin && osc_cos == init_cos, "R8 write beats tick", longint'(osc_cos), longint'(init_cos));
        check(done == 0, "R3 done cleared by start", longint'(done), 0);

        // R8 abort by writing 0 keeps old sums
        keep_s = sum_sin; keep_c = sum_cos;
        host_write(2);
        run(10, 1, 3);
        host_write(0);
        run(6, 1, 9);
        check(done == 0 && tmr_q == 0, "R8 abort leaves done low", longint'(done), 0);
        check(sum_sin == keep_s && sum_cos == keep_c, "R8 abort keeps sums", longint'(sum_sin), keep_s);

        // R7 period of 2: empty window
        period = tmr_t'(2);
        host_write(1);
        host_write(2);
        @(negedge clk);
        check(done == 1 && sum_sin == 0 && sum_cos == 0, "R7 empty window", longint'(sum_sin), 0);

        // R9 sums and done hold while idle
        run(20, 1, 17);
        check(done == 1 && sum_sin == 0, "R9 hold after completion", longint'(done), 1);

        // R5 injection saturation
        init_sin = -16'sd32768; init_cos = -16'sd32768;
        k_ss = 16'sd16384; k_sc = 16'sd0; k_cs = 16'sd0; k_cc = 16'sd16384;
        inj_gain = -8'sd128;
        host_write(1);
        vout = -16'sd32768;
        #1;
        check(vin == 16'sd32767, "R5 injection saturates high", longint'(vin), 32767);
        inj_gain = 8'sd127;
        #1;
        check(vin == -16'sd32768, "R5 injection saturates low", longint'(vin), -32768);

        // R10 full-scale window of 4094 ticks
        period = tmr_t'(4096);
        host_write(2);
        vout = -16'sd32768; tick = 1'b1;
        while (!done) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        full = 64'sd4094 * (64'sd1 <<< 30);
        check(longint'(sum_sin) == full && longint'(sum_cos) == full, "R10 full-scale sum", longint'(sum_sin), full);

        // R4/R6 continuous ticks with rotation
        set_rotation(); init_sin = 16'sd5000; init_cos = -16'sd9000; inj_gain = -8'sd50;
        period = tmr_t'(100);
        host_write(1);
        run(30, 1, 21);
        host_write(2);
        run_to_done(1, 29);
        check(done == 1 && sum_sin == m_rs, "R6 continuous window", longint'(sum_sin), m_rs);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule